// File: doc/BRIEF.md
# Carrier Lock Detector Accumulator

This block judges whether a carrier tracking loop has settled. Over a programmable integration period, counted in valid samples, it sums the unsigned phase-error magnitude into an 18-bit accumulator. A second 18-bit accumulator sums either the frequency-error magnitude or a false-lock indicator bit. Neither accumulator is compared against a threshold. At the start of a period each accumulator is loaded with a preload that sits below full scale by the wanted threshold. The threshold counts as crossed when the sum carries out of the top bit.

Two parameter sets are provided, one for acquisition and one for track, and a mode input selects between them. In acquisition, a stepped option can hold off reporting for a programmed number of whole integration periods after a restart, so the loop can settle first. At the end of each reported period the block raises a one-cycle done strobe and updates the lock and false-lock flags. The flags then hold until the next reported period.

Top module: `carrier_lock_detect`

## Requirements
- R1: While reset is high and in the cycle after it, `period_done`, `lock_flag` and `false_lock_flag` are 0.
- R2: An integration period is `field + 2` valid samples, where `field` is the integration-count input of the active mode. Cycles with `sample_vld` low are not counted. `period_done` is high for exactly the one cycle after the clock edge that took the last sample.
- R3: The accumulator holds 7 fractional bits. A 16-bit preload `P` occupies bits 17..2, so its value is `P*4` in LSB units. `lock_flag` after a reported period is 1 exactly when `P*4` plus the sum of the period's `phase_mag` values is at least 2^18, that is, when the 18-bit accumulator rolls over.
- R4: With `mode_trk` = 0 the acquisition lock preload and integration count are used. With `mode_trk` = 1 the track lock preload and integration count are used, and the fields of the other mode have no effect.
- R5: `fl_sel` = 0 feeds `freq_mag` to the false-lock accumulator. `fl_sel` = 1 feeds `fl_bit`, weighted 2^7 LSBs (1.0). The false-lock accumulator always uses the track false-lock preload, with the same rollover rule as R3, and the acquisition false-lock preload has no effect.
- R6: In acquisition mode with `stepped_en` = 1, the first `dwell + 1` periods after reset or after a mode change produce no `period_done`, and the first strobe follows the end of period `dwell + 2`. In track mode, or with `stepped_en` = 0, there is no hold-off.
- R7: `lock_flag` and `false_lock_flag` change only in the cycle in which `period_done` is high. Otherwise they hold their value.
- R8: A change of `mode_trk` restarts the integration period. Samples already taken in the unfinished period are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_trk | input | 1 | 0 acquisition, 1 track |
| stepped_en | input | 1 | Enables dwell hold-off in acquisition |
| fl_sel | input | 1 | False-lock input select (0 frequency magnitude, 1 indicator bit) |
| sample_vld | input | 1 | Sample strobe |
| phase_mag | input | MAG_W | Phase-error magnitude, 7 fractional bits |
| freq_mag | input | MAG_W | Frequency-error magnitude, 7 fractional bits |
| fl_bit | input | 1 | False-lock indicator |
| icnt_acq | input | CNT_W | Acquisition samples per period minus two |
| icnt_trk | input | CNT_W | Track samples per period minus two |
| dwell | input | DWELL_W | Hold-off periods minus one |
| lock_pre_acq | input | 16 | Acquisition lock preload |
| lock_pre_trk | input | 16 | Track lock preload |
| fl_pre_acq | input | 16 | Acquisition false-lock preload (unused) |
| fl_pre_trk | input | 16 | Track false-lock preload |
| period_done | output | 1 | One-cycle end-of-reported-period strobe |
| lock_flag | output | 1 | Lock result of last reported period |
| false_lock_flag | output | 1 | False-lock result of last reported period |

## Verification
The bench builds the block with `CNT_W` = 4, `DWELL_W` = 3 and `MAG_W` = 12. With these values every integration length from 2 to 17 samples and every dwell setting from 0 to 7 can be swept exhaustively in both modes. For each length, the preloads are set one LSB step either side of the rollover boundary, using the exact sum of the sample pattern, so the lock and false-lock results switch between 0 and 1 right at 2^18. Idle gaps between samples, garbage in the preloads and counts of the unused mode, and a mode change in the middle of a period are all checked at the outputs.

// File: rtl/cld_pkg.sv
package cld_pkg;
    localparam int ACC_W  = 18;
    localparam int FRAC_W = 7;
    localparam int PRE_W  = 16;
    localparam int PAD_W  = ACC_W - PRE_W;

    typedef enum logic {
        MODE_ACQ = 1'b0,
        MODE_TRK = 1'b1
    } mode_e;

    typedef struct packed {
        logic first;   // sample opens a new period
        logic last;    // sample closes the period
        logic report;  // closing sample of a period that is reported
    } period_ev_t;

    function automatic logic [ACC_W-1:0] align_preload(input logic [PRE_W-1:0] p);
        return {p, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/cld_period_ctrl.sv
module cld_period_ctrl
    import cld_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int DWELL_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               mode_trk,
    input  logic               dwell_en,
    input  logic               vld,
    input  logic [CNT_W-1:0]   icnt,
    input  logic [DWELL_W-1:0] dwell,
    output period_ev_t         ev
);
    localparam int CW = CNT_W + 1;
    localparam int DW = DWELL_W + 1;

    logic [CW-1:0] cnt;
    logic [DW-1:0] dwell_left;
    logic [CW-1:0] eff_cnt;
    logic [CW-1:0] limit;
    logic [DW-1:0] dwell_load;
    logic [DW-1:0] dwell_base;

    always_comb begin
        limit      = {1'b0, icnt} + CW'(1);
        dwell_load = dwell_en ? ({1'b0, dwell} + DW'(1)) : '0;
        eff_cnt    = restart ? '0 : cnt;
        dwell_base = restart ? dwell_load : dwell_left;
        ev.first   = (eff_cnt == '0);
        ev.last    = vld && (eff_cnt >= limit);
        ev.report  = ev.last && (dwell_base == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            dwell_left <= dwell_load;
        end else begin
            if (vld)
                cnt <= ev.last ? '0 : eff_cnt + CW'(1);
            else
                cnt <= eff_cnt;
            if (ev.last && dwell_base != '0)
                dwell_left <= dwell_base - DW'(1);
            else
                dwell_left <= dwell_base;
        end
    end

    // R6: no hold-off remains once track mode is running
    a_r6_track_no_dwell: assert property (@(posedge clk) disable iff (rst)
        (mode_trk && !restart) |-> (dwell_left == '0));
endmodule

// File: rtl/cld_rollover_acc.sv
module cld_rollover_acc
    import cld_pkg::*;
#(
    parameter int MAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  period_ev_t       ev,
    input  logic [PRE_W-1:0] preload,
    input  logic [MAG_W-1:0] mag,
    output logic             flag
);
    localparam int SUM_W = ACC_W + 1;
    localparam int EXT_W = SUM_W - MAG_W;

    logic [ACC_W-1:0] acc;
    logic             sticky;
    logic [ACC_W-1:0] base;
    logic [SUM_W-1:0] sum;
    logic             hit;

    always_comb begin
        base = ev.first ? align_preload(preload) : acc;
        sum  = {1'b0, base} + {{EXT_W{1'b0}}, mag};
        hit  = (ev.first ? 1'b0 : sticky) | sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            sticky <= 1'b0;
            flag   <= 1'b0;
        end else if (vld) begin
            acc    <= sum[ACC_W-1:0];
            sticky <= hit;
            if (ev.report)
                flag <= hit;
        end
    end

    // R3: a rollover is only ever recorded from an accepted sample
    a_r3_sticky_on_sample: assert property (@(posedge clk) disable iff (rst)
        $rose(sticky) |-> $past(vld));
endmodule

// File: rtl/carrier_lock_detect.sv
module carrier_lock_detect
    import cld_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int DWELL_W = 7,
    parameter int MAG_W   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_trk,
    input  logic               stepped_en,
    input  logic               fl_sel,
    input  logic               sample_vld,
    input  logic [MAG_W-1:0]   phase_mag,
    input  logic [MAG_W-1:0]   freq_mag,
    input  logic               fl_bit,
    input  logic [CNT_W-1:0]   icnt_acq,
    input  logic [CNT_W-1:0]   icnt_trk,
    input  logic [DWELL_W-1:0] dwell,
    input  logic [15:0]        lock_pre_acq,
    input  logic [15:0]        lock_pre_trk,
    input  logic [15:0]        fl_pre_acq,
    input  logic [15:0]        fl_pre_trk,
    output logic               period_done,
    output logic               lock_flag,
    output logic               false_lock_flag
);
    localparam logic [MAG_W-1:0] ONE_MAG = MAG_W'(1) << FRAC_W;

    mode_e            mode, mode_q;
    logic             restart;
    logic             dwell_en;
    logic [CNT_W-1:0] icnt;
    logic [PRE_W-1:0] lock_pre;
    logic [MAG_W-1:0] fl_mag;
    logic [PRE_W-1:0] fl_pre_unused;
    period_ev_t       ev;

    always_comb begin
        mode          = mode_e'(mode_trk);
        restart       = (mode != mode_q);
        dwell_en      = stepped_en && (mode == MODE_ACQ);
        icnt          = (mode == MODE_TRK) ? icnt_trk : icnt_acq;
        lock_pre      = (mode == MODE_TRK) ? lock_pre_trk : lock_pre_acq;
        fl_mag        = fl_sel ? (fl_bit ? ONE_MAG : '0) : freq_mag;
        fl_pre_unused = fl_pre_acq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= mode;
            period_done <= 1'b0;
        end else begin
            mode_q      <= mode;
            period_done <= ev.report;
        end
    end

    cld_period_ctrl #(.CNT_W(CNT_W), .DWELL_W(DWELL_W)) u_ctrl (
        .clk(clk), .rst(rst), .restart(restart), .mode_trk(mode_trk),
        .dwell_en(dwell_en), .vld(sample_vld), .icnt(icnt), .dwell(dwell),
        .ev(ev)
    );

    cld_rollover_acc #(.MAG_W(MAG_W)) u_lock_acc (
        .clk(clk), .rst(rst), .vld(sample_vld), .ev(ev),
        .preload(lock_pre), .mag(phase_mag), .flag(lock_flag)
    );

    cld_rollover_acc #(.MAG_W(MAG_W)) u_fl_acc (
        .clk(clk), .rst(rst), .vld(sample_vld), .ev(ev),
        .preload(fl_pre_trk), .mag(fl_mag), .flag(false_lock_flag)
    );

    // R2: the done strobe follows an accepted sample and lasts one cycle
    a_r2_done_after_sample: assert property (@(posedge clk) disable iff (rst)
        period_done |-> $past(sample_vld));
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        period_done |=> !period_done);
    // R7: results change only with the strobe
    a_r7_lock_hold: assert property (@(posedge clk) disable iff (rst)
        !period_done |-> $stable(lock_flag));
    a_r7_fl_hold: assert property (@(posedge clk) disable iff (rst)
        !period_done |-> $stable(false_lock_flag));
endmodule

// File: tb/carrier_lock_detect_bench.sv
module carrier_lock_detect_bench;
    localparam int CNT_W = 4, DWELL_W = 3, MAG_W = 12;
    localparam longint FULL = 262144;

    logic clk = 1'b0, rst = 1'b1;
    logic mode_trk = 0, stepped_en = 0, fl_sel = 0, sample_vld = 0, fl_bit = 0;
    logic [MAG_W-1:0] phase_mag = '0, freq_mag = '0;
    logic [CNT_W-1:0] icnt_acq = '0, icnt_trk = '0;
    logic [DWELL_W-1:0] dwell = '0;
    logic [15:0] lock_pre_acq = '0, lock_pre_trk = '0, fl_pre_acq = '0, fl_pre_trk = '0;
    logic period_done, lock_flag, false_lock_flag;

    int errs = 0, checks = 0;
    bit finished = 0;

    always #10ns clk = ~clk;

    carrier_lock_detect #(.CNT_W(CNT_W), .DWELL_W(DWELL_W), .MAG_W(MAG_W)) u_carrier_lock_detect (
        .clk(clk), .rst(rst), .mode_trk(mode_trk), .stepped_en(stepped_en),
        .fl_sel(fl_sel), .sample_vld(sample_vld), .phase_mag(phase_mag),
        .freq_mag(freq_mag), .fl_bit(fl_bit), .icnt_acq(icnt_acq),
        .icnt_trk(icnt_trk), .dwell(dwell), .lock_pre_acq(lock_pre_acq),
        .lock_pre_trk(lock_pre_trk), .fl_pre_acq(fl_pre_acq), .fl_pre_trk(fl_pre_trk),
        .period_done(period_done), .lock_flag(lock_flag), .false_lock_flag(false_lock_flag)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ph_at(int seed, int i); return (seed*37 + i*113 + 5) % 4096; endfunction
    function automatic int fr_at(int seed, int i); return (seed*91 + i*29 + 11) % 4096; endfunction
    function automatic bit fb_at(int seed, int i); return ((seed + i) % 3) == 0; endfunction

    function automatic longint pick_pre(longint s, int delta);
        longint p;
        p = (FULL - s + 3) / 4 + delta;
        if (p < 0) p = 0;
        if (p > 65535) p = 65535;
        return p;
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // one valid sample; returns the done strobe seen one cycle later
    task automatic sample(input int ph, input int fr, input bit fb, output bit done);
        sample_vld = 1; phase_mag = MAG_W'(ph); freq_mag = MAG_W'(fr); fl_bit = fb;
        @(negedge clk);
        done = period_done;
        sample_vld = 0;
    endtask

    // full period in the current mode with preloads at the rollover boundary
    task automatic run_period(input int n, input int seed, input int dl, input int df, input string tag);
        longint ps = 0, fs = 0, pl, pf;
        bit done, exp_l, exp_f, held;
        for (int i = 0; i < n; i++) begin
            ps += ph_at(seed, i);
            fs += fl_sel ? (fb_at(seed, i) ? 128 : 0) : fr_at(seed, i);
        end
        pl = pick_pre(ps, dl);
        pf = pick_pre(fs, df);
        if (mode_trk) begin
            lock_pre_trk = 16'(pl); lock_pre_acq = 16'(pl ^ 16'h5a5a);
            icnt_trk = CNT_W'(n - 2); icnt_acq = CNT_W'(17 - n);
        end else begin
            lock_pre_acq = 16'(pl); lock_pre_trk = 16'(pl ^ 16'h5a5a);
            icnt_acq = CNT_W'(n - 2); icnt_trk = CNT_W'(17 - n);
        end
        fl_pre_trk = 16'(pf); fl_pre_acq = 16'(pf ^ 16'h3c3c);
        exp_l = (pl * 4 + ps) >= FULL;
        exp_f = (pf * 4 + fs) >= FULL;
        for (int i = 0; i < n; i++) begin
            sample(ph_at(seed, i), fr_at(seed, i), fb_at(seed, i), done);
            if (i < n - 1) begin
                if (done) chk(0, {"R2 early done ", tag}, 1, 0);
            end else begin
                chk(done == 1, {"R2 done at period end ", tag}, done, 1);
                chk(lock_flag == exp_l, {"R3/R4 lock ", tag}, lock_flag, exp_l);
                chk(false_lock_flag == exp_f, {"R5 false lock ", tag}, false_lock_flag, exp_f);
            end
            if (i % 4 == 2) idle(2);
        end
        held = lock_flag;
        idle(1);
        chk(period_done == 0, {"R2 single pulse ", tag}, period_done, 0);
        idle(3);
        chk(lock_flag == held, {"R7 hold ", tag}, lock_flag, held);
    endtask

    task automatic do_reset();
        rst = 1; sample_vld = 0;
        idle(3);
        chk(period_done == 0 && lock_flag == 0 && false_lock_flag == 0, "R1 in reset",
            {period_done, lock_flag, false_lock_flag}, 0);
        rst = 0;
        idle(1);
        chk(period_done == 0 && lock_flag == 0 && false_lock_flag == 0, "R1 after reset",
            {period_done, lock_flag, false_lock_flag}, 0);
    endtask

    // count samples until the first done strobe
    task automatic count_to_done(input int expect_n, input string tag);
        bit done = 0;
        int got = 0;
        while (!done && got < 200) begin
            sample(got % 4096, 7, 0, done);
            got++;
        end
        chk(got == expect_n, {"R6 dwell ", tag}, got, expect_n);
    endtask

    initial begin
        bit done;
        do_reset();
        // R3, R4, R5 sweep in acquisition
        for (int f = 0; f < 16; f++)
            for (int d = -1; d <= 0; d++) begin
                fl_sel = (f % 2);
                run_period(f + 2, f * 3 + d + 7, d, -1 - d, "acq");
            end
        // track mode (mode change also restarts, R8)
        mode_trk = 1; idle(2);
        for (int f = 0; f < 16; f++)
            for (int d = -1; d <= 0; d++) begin
                fl_sel = ((f / 2) % 2);
                run_period(f + 2, f * 5 + d + 3, -1 - d, d, "trk");
            end
        // R8: abandon a partial period by a mode change
        mode_trk = 0; idle(2);
        icnt_acq = 4'd4;
        for (int i = 0; i < 3; i++) sample(4095, 4095, 1, done);
        mode_trk = 1; idle(2);
        mode_trk = 0; idle(2);
        run_period(6, 11, 0, -1, "R8 restart");
        run_period(6, 12, -1, 0, "R8 restart");
        // R6: dwell hold-off
        for (int d = 0; d < 8; d++) begin
            stepped_en = 1; dwell = DWELL_W'(d); mode_trk = 0; icnt_acq = 4'd1;
            do_reset();
            count_to_done((d + 2) * 3, "acq");
        end
        stepped_en = 1; dwell = 3'd5; icnt_trk = 4'd2;
        mode_trk = 1; idle(2);
        count_to_done(4, "track none");
        stepped_en = 0; mode_trk = 0; icnt_acq = 4'd2; idle(2);
        count_to_done(4, "stepped off");
        stepped_en = 1; dwell = 3'd1; mode_trk = 1; idle(2); mode_trk = 0; idle(2);
        count_to_done(12, "after mode change");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule